// File: doc/BRIEF.md
# Host Port Strobe Combiner and Capture Front End

This block sits at the pin edge of a processor's host port. A host drives an active-low chip select and two data-strobe pins. The block merges them into one internal access strobe. The strobe is active only while chip select is low and the two strobe pins disagree, which is an exclusive-NOR of the pair qualified by chip select. Because of this, hosts with separate read and write strobes, hosts with a single active-low strobe, and hosts with a single active-high strobe can all be wired without glue logic.

Every pin is brought into the system clock domain. Chip select, both strobes and the address-strobe pin pass through a synchroniser chain of configurable depth. The remaining inputs are taken from a registered snapshot.

When the strobe goes active, the block latches the access-type code, the halfword select and the direction. If the direction is read, it also emits a one-cycle read-start pulse. When the strobe returns inactive, it latches the byte enables and the write data. If the latched direction is write, it emits a one-cycle write-start pulse. A ready output tells the host to wait while the access engine is busy, but only while chip select is asserted.

Top module: `hostport_front`

## Requirements
- R1: The internal strobe is active only when the synchronised chip select is 0 and exactly one of `ds_a_n`, `ds_b_n` is 0. With chip select at 1, or with both strobe pins equal, no start pulse is produced.
- R2: With `ds_b_n` tied to 0, `ds_a_n` acts as an active-high strobe: driving it to 1 (with chip select 0) starts an access.
- R3: On each strobe activation edge with the address-strobe pin at 1, `kind_q`, `half_q` and `rnw_q` load the values of `kind_i`, `half_i` and `rnw_i`. They hold between such edges.
- R4: A strobe activation edge produces a single-cycle `rd_start_o` when the direction in force is read (`rnw` = 1), for every `kind` value 0 to 3.
- R5: A strobe release edge produces a single-cycle `wr_start_o` when the latched direction is write (`rnw_q` = 0). `rd_start_o` and `wr_start_o` are never both 1.
- R6: On each strobe release edge, `be_q` and `wdata_q` load `be_i` and `wdata_i`. They hold between such edges.
- R7: Chip select may remain 0 across consecutive accesses. Each new activation edge is a separate access and yields its own start pulse.
- R8: `rdy_n_o` is 1 only while the synchronised chip select is 0 and `busy_i` is 1. Otherwise it is 0.
- R9: If the address-strobe pin is 0 at an activation edge, the control fields keep their previous values, and the previously latched direction decides whether a read starts.
- R10: Synchronous active-high reset clears all latched fields and both start pulses, and treats all select pins as inactive.
- R11: A select-pin change is reflected in a start pulse after exactly SYNC_STAGES+1 clock edges. Data pins are sampled one cycle before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host chip select, active low |
| ds_a_n | input | 1 | First data-strobe pin |
| ds_b_n | input | 1 | Second data-strobe pin |
| as_n | input | 1 | Address-strobe pin; held 1 for strobe-edge control capture |
| kind_i | input | 2 | Access-type code |
| half_i | input | 1 | Halfword select |
| rnw_i | input | 1 | Direction, 1 = read |
| be_i | input | BE_W | Byte enables |
| wdata_i | input | DATA_W | Write data |
| busy_i | input | 1 | Access engine busy |
| kind_q | output | 2 | Latched access type |
| half_q | output | 1 | Latched halfword select |
| rnw_q | output | 1 | Latched direction |
| be_q | output | BE_W | Latched byte enables |
| wdata_q | output | DATA_W | Latched write data |
| rd_start_o | output | 1 | Read-start pulse |
| wr_start_o | output | 1 | Write-start pulse |
| rdy_n_o | output | 1 | Host ready, 1 = wait |

## Verification
The bench builds the block with SYNC_STAGES = 3, a 16-bit data word and two byte enables. The non-default synchroniser depth shows that latency follows the parameter rather than a fixed two-stage chain. The reference model delays its pin history by the same parameter, so the model and the design must agree cycle for cycle on every output. The stimulus reaches all four access-type codes, all three host wiring styles, chip select held across back-to-back accesses, a strobe edge with the address strobe low, and busy toggling with chip select both asserted and released.

// File: rtl/hostport_pkg.sv
package hostport_pkg;
   localparam int KIND_W = 2;

   typedef struct packed {
      logic [KIND_W-1:0] kind;
      logic              half;
      logic              rnw;
   } ctrl_t;

   // Order of select pins inside the synchroniser word
   localparam int SEL_CS  = 0;
   localparam int SEL_DSA = 1;
   localparam int SEL_DSB = 2;
   localparam int SEL_AS  = 3;
   localparam int SEL_W   = 4;
endpackage

// File: rtl/hostport_sync.sv
module hostport_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain[g] <= RST_VAL;
            else     chain[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain[g] <= RST_VAL;
            else     chain[g] <= chain[g-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hostport_strobe.sv
module hostport_strobe (
   input  logic clk,
   input  logic rst,
   input  logic cs_n,
   input  logic ds_a_n,
   input  logic ds_b_n,
   output logic strobe_n,
   output logic act_edge,
   output logic rel_edge
);
   logic strobe_hist_n;

   // Active (low) only with chip select low and the two strobe pins differing
   assign strobe_n = cs_n | ~(ds_a_n ^ ds_b_n);

   always_ff @(posedge clk) begin
      if (rst) strobe_hist_n <= 1'b1;
      else     strobe_hist_n <= strobe_n;
   end

   assign act_edge =  strobe_hist_n & ~strobe_n;
   assign rel_edge = ~strobe_hist_n &  strobe_n;
endmodule

// File: rtl/hostport_capture.sv
module hostport_capture
   import hostport_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BE_W   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              act_edge,
   input  logic              rel_edge,
   input  logic              as_hi,
   input  ctrl_t             ctrl_snap,
   input  logic [BE_W-1:0]   be_snap,
   input  logic [DATA_W-1:0] wd_snap,
   output ctrl_t             ctrl_q,
   output logic [BE_W-1:0]   be_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              rd_start,
   output logic              wr_start
);
   logic take_ctrl;
   logic dir_read;

   assign take_ctrl = act_edge & as_hi;
   assign dir_read  = take_ctrl ? ctrl_snap.rnw : ctrl_q.rnw;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q   <= '0;
         rd_start <= 1'b0;
      end else begin
         if (take_ctrl) ctrl_q <= ctrl_snap;
         rd_start <= act_edge & dir_read;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         be_q     <= '0;
         wdata_q  <= '0;
         wr_start <= 1'b0;
      end else begin
         if (rel_edge) begin
            be_q    <= be_snap;
            wdata_q <= wd_snap;
         end
         wr_start <= rel_edge & ~ctrl_q.rnw;
      end
   end
endmodule

// File: rtl/hostport_front.sv
module hostport_front
   import hostport_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int BE_W        = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              ds_a_n,
   input  logic              ds_b_n,
   input  logic              as_n,
   input  logic [1:0]        kind_i,
   input  logic              half_i,
   input  logic              rnw_i,
   input  logic [BE_W-1:0]   be_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              busy_i,
   output logic [1:0]        kind_q,
   output logic              half_q,
   output logic              rnw_q,
   output logic [BE_W-1:0]   be_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              rd_start_o,
   output logic              wr_start_o,
   output logic              rdy_n_o
);
   localparam logic [SEL_W-1:0] SEL_IDLE = '1;

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("hostport_front: SYNC_STAGES must be at least 2");
   end
   if (DATA_W < 1 || BE_W < 1) begin : g_chk_w
      $error("hostport_front: DATA_W and BE_W must be positive");
   end
   if (KIND_W != 2) begin : g_chk_kind
      $error("hostport_front: access-type field must be two bits");
   end

   logic [SEL_W-1:0]  sel_pins;
   logic [SEL_W-1:0]  sel_s;
   ctrl_t             ctrl_pins;
   ctrl_t             ctrl_snap;
   ctrl_t             ctrl_q;
   logic [BE_W-1:0]   be_snap;
   logic [DATA_W-1:0] wd_snap;
   logic              strobe_n;
   logic              act_edge;
   logic              rel_edge;

   always_comb begin
      sel_pins          = '0;
      sel_pins[SEL_CS]  = cs_n;
      sel_pins[SEL_DSA] = ds_a_n;
      sel_pins[SEL_DSB] = ds_b_n;
      sel_pins[SEL_AS]  = as_n;
   end

   hostport_sync #(
      .W       (SEL_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SEL_IDLE)
   ) u_sel_sync (
      .clk (clk),
      .rst (rst),
      .d   (sel_pins),
      .q   (sel_s)
   );

   // Single-register snapshot of the slower control and data pins
   assign ctrl_pins = '{kind: kind_i, half: half_i, rnw: rnw_i};

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_snap <= '0;
         be_snap   <= '0;
         wd_snap   <= '0;
      end else begin
         ctrl_snap <= ctrl_pins;
         be_snap   <= be_i;
         wd_snap   <= wdata_i;
      end
   end

   hostport_strobe u_strobe (
      .clk      (clk),
      .rst      (rst),
      .cs_n     (sel_s[SEL_CS]),
      .ds_a_n   (sel_s[SEL_DSA]),
      .ds_b_n   (sel_s[SEL_DSB]),
      .strobe_n (strobe_n),
      .act_edge (act_edge),
      .rel_edge (rel_edge)
   );

   hostport_capture #(
      .DATA_W (DATA_W),
      .BE_W   (BE_W)
   ) u_capture (
      .clk       (clk),
      .rst       (rst),
      .act_edge  (act_edge),
      .rel_edge  (rel_edge),
      .as_hi     (sel_s[SEL_AS]),
      .ctrl_snap (ctrl_snap),
      .be_snap   (be_snap),
      .wd_snap   (wd_snap),
      .ctrl_q    (ctrl_q),
      .be_q      (be_q),
      .wdata_q   (wdata_q),
      .rd_start  (rd_start_o),
      .wr_start  (wr_start_o)
   );

   assign kind_q  = ctrl_q.kind;
   assign half_q  = ctrl_q.half;
   assign rnw_q   = ctrl_q.rnw;
   assign rdy_n_o = ~sel_s[SEL_CS] & busy_i;
endmodule

// File: rtl/hostport_front_chk.sv
module hostport_front_chk #(
   parameter int DATA_W = 16,
   parameter int BE_W   = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              act_edge,
   input logic              rel_edge,
   input logic              busy_i,
   input logic [1:0]        kind_q,
   input logic              half_q,
   input logic              rnw_q,
   input logic [BE_W-1:0]   be_q,
   input logic [DATA_W-1:0] wdata_q,
   input logic              rd_start_o,
   input logic              wr_start_o,
   input logic              rdy_n_o
);
   a_r4_rd_single: assert property (@(posedge clk) disable iff (rst)
      rd_start_o |=> !rd_start_o);

   a_r5_wr_single: assert property (@(posedge clk) disable iff (rst)
      wr_start_o |=> !wr_start_o);

   a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
      !(rd_start_o && wr_start_o));

   a_r4_rd_is_read: assert property (@(posedge clk) disable iff (rst)
      rd_start_o |-> rnw_q);

   a_r5_wr_is_write: assert property (@(posedge clk) disable iff (rst)
      wr_start_o |-> !rnw_q);

   a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
      !act_edge |=> ($stable(kind_q) && $stable(half_q) && $stable(rnw_q)));

   a_r6_data_hold: assert property (@(posedge clk) disable iff (rst)
      !rel_edge |=> ($stable(be_q) && $stable(wdata_q)));

   a_r8_ready_idle: assert property (@(posedge clk) disable iff (rst)
      !busy_i |-> !rdy_n_o);

   a_r1_no_start_without_edge: assert property (@(posedge clk) disable iff (rst)
      !act_edge |=> !rd_start_o);
endmodule

bind hostport_front hostport_front_chk #(
   .DATA_W (DATA_W),
   .BE_W   (BE_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .act_edge   (act_edge),
   .rel_edge   (rel_edge),
   .busy_i     (busy_i),
   .kind_q     (kind_q),
   .half_q     (half_q),
   .rnw_q      (rnw_q),
   .be_q       (be_q),
   .wdata_q    (wdata_q),
   .rd_start_o (rd_start_o),
   .wr_start_o (wr_start_o),
   .rdy_n_o    (rdy_n_o)
);

// File: tb/hostport_front_tb.sv
`timescale 1ns/1ps
module hostport_front_tb;
   localparam int DW = 16;
   localparam int BW = 2;
   localparam int S  = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cs_n = 1'b1, ds_a_n = 1'b1, ds_b_n = 1'b1, as_n = 1'b1;
   logic [1:0]    kind_i = '0;
   logic          half_i = 1'b0, rnw_i = 1'b0, busy_i = 1'b0;
   logic [BW-1:0] be_i = '0;
   logic [DW-1:0] wdata_i = '0;
   logic [1:0]    kind_q;
   logic          half_q, rnw_q, rd_start_o, wr_start_o, rdy_n_o;
   logic [BW-1:0] be_q;
   logic [DW-1:0] wdata_q;

   int tests = 0, fails = 0, rd_cnt = 0, wr_cnt = 0;
   bit done = 0;

   always #5 clk = ~clk;

   hostport_front #(.DATA_W(DW), .BE_W(BW), .SYNC_STAGES(S)) u_dut (
      .clk(clk), .rst(rst), .cs_n(cs_n), .ds_a_n(ds_a_n), .ds_b_n(ds_b_n),
      .as_n(as_n), .kind_i(kind_i), .half_i(half_i), .rnw_i(rnw_i),
      .be_i(be_i), .wdata_i(wdata_i), .busy_i(busy_i), .kind_q(kind_q),
      .half_q(half_q), .rnw_q(rnw_q), .be_q(be_q), .wdata_q(wdata_q),
      .rd_start_o(rd_start_o), .wr_start_o(wr_start_o), .rdy_n_o(rdy_n_o));

   // ---------------- behavioural reference ----------------
   typedef struct {
      bit cs, a, b, as_;
      bit [1:0] kind;
      bit half, rnw;
      bit [BW-1:0] be;
      bit [DW-1:0] wd;
   } smp_t;

   smp_t hist [0:7];
   bit [1:0]    m_kind;
   bit          m_half, m_rnw, m_rd, m_wr;
   bit [BW-1:0] m_be;
   bit [DW-1:0] m_wd;

   function automatic bit strobe_off(smp_t s);
      if (s.cs) return 1'b1;
      return (s.a == s.b);
   endfunction

   function automatic smp_t idle_smp();
      smp_t s;
      s.cs = 1; s.a = 1; s.b = 1; s.as_ = 1;
      s.kind = 0; s.half = 0; s.rnw = 0; s.be = 0; s.wd = 0;
      return s;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 8; i++) hist[i] = idle_smp();
         m_kind = 0; m_half = 0; m_rnw = 0; m_be = 0; m_wd = 0;
         m_rd = 0; m_wr = 0;
      end else begin
         bit now_off, was_off, act, rel, old_rnw;
         smp_t s;
         for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
         s.cs = cs_n; s.a = ds_a_n; s.b = ds_b_n; s.as_ = as_n;
         s.kind = kind_i; s.half = half_i; s.rnw = rnw_i;
         s.be = be_i; s.wd = wdata_i;
         hist[0] = s;
         now_off = strobe_off(hist[S]);
         was_off = strobe_off(hist[S+1]);
         act = was_off && !now_off;
         rel = !was_off && now_off;
         old_rnw = m_rnw;
         m_wr = rel && !old_rnw;
         if (act && hist[S].as_) begin
            m_kind = hist[1].kind; m_half = hist[1].half; m_rnw = hist[1].rnw;
         end
         m_rd = act && m_rnw;
         if (rel) begin
            m_be = hist[1].be; m_wd = hist[1].wd;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (!rst && !done) begin
         chk("R4 rd_start", 32'(rd_start_o), 32'(m_rd));
         chk("R5 wr_start", 32'(wr_start_o), 32'(m_wr));
         chk("R3 kind_q",   32'(kind_q),     32'(m_kind));
         chk("R3 half_q",   32'(half_q),     32'(m_half));
         chk("R3 rnw_q",    32'(rnw_q),      32'(m_rnw));
         chk("R6 be_q",     32'(be_q),       32'(m_be));
         chk("R6 wdata_q",  32'(wdata_q),    32'(m_wd));
         chk("R8 rdy_n_o",  32'(rdy_n_o),    32'((!hist[S-1].cs) && busy_i));
         if (rd_start_o) rd_cnt++;
         if (wr_start_o) wr_cnt++;
      end
   end

   // ---------------- stimulus ----------------
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // hi: ds_a_n used as active-high strobe with ds_b_n tied 0
   task automatic access(input bit hi, input bit [1:0] k, input bit h, input bit rw,
                         input bit asn, input bit [BW-1:0] be, input bit [DW-1:0] wd);
      kind_i = k; half_i = h; rnw_i = rw; as_n = asn; be_i = be; wdata_i = wd;
      ds_b_n = hi ? 1'b0 : 1'b1;
      ds_a_n = hi ? 1'b0 : 1'b1;
      cs_n = 1'b0;
      idle(3);
      ds_a_n = hi ? 1'b1 : 1'b0;
      idle(6);
      ds_a_n = hi ? 1'b0 : 1'b1;
      idle(6);
      as_n = 1'b1;
   endtask

   initial begin
      int r0, w0;
      idle(6);
      // R10: reset state
      chk("R10 rd_start", 32'(rd_start_o), 0);
      chk("R10 wr_start", 32'(wr_start_o), 0);
      chk("R10 fields", {kind_q, half_q, rnw_q, be_q, wdata_q}, 0);
      rst = 1'b0;
      idle(4);

      // R4: reads with every access-type code, low-true strobe
      r0 = rd_cnt;
      for (int k = 0; k < 4; k++) access(0, 2'(k), k[0], 1, 1, 2'b01, 16'h1000 + 16'(k));
      chk("R4 read count", 32'(rd_cnt - r0), 4);

      // R5/R6: writes with varied data
      w0 = wr_cnt;
      access(0, 2'd1, 0, 0, 1, 2'b10, 16'hA5C3);
      chk("R6 wdata", 32'(wdata_q), 32'hA5C3);
      access(0, 2'd3, 1, 0, 1, 2'b11, 16'h5A3C);
      chk("R6 be", 32'(be_q), 3);
      chk("R5 write count", 32'(wr_cnt - w0), 2);

      // R11: latency from strobe pin to read pulse
      cs_n = 0; ds_a_n = 1; ds_b_n = 1; rnw_i = 1; as_n = 1; idle(3);
      ds_a_n = 0;
      idle(S);
      chk("R11 no pulse before S+1 edges", 32'(rd_start_o), 0);
      idle(1);
      chk("R11 pulse at S+1 edges", 32'(rd_start_o), 1);
      ds_a_n = 1; idle(6);

      // R2: active-high strobe on ds_a_n with ds_b_n tied low
      w0 = wr_cnt;
      access(1, 2'd2, 0, 0, 1, 2'b01, 16'h0F0F);
      chk("R2 high-true write count", 32'(wr_cnt - w0), 1);
      chk("R2 high-true data", 32'(wdata_q), 32'h0F0F);

      // R1: both strobes low, and chip select high: no starts
      r0 = rd_cnt; w0 = wr_cnt;
      rnw_i = 1; cs_n = 0; ds_a_n = 1; ds_b_n = 1; idle(3);
      ds_a_n = 0; ds_b_n = 0; idle(6);
      ds_a_n = 1; ds_b_n = 1; idle(6);
      cs_n = 1; idle(4);
      ds_a_n = 0; idle(6); ds_a_n = 1; idle(6);
      chk("R1 no start pulses", 32'((rd_cnt - r0) + (wr_cnt - w0)), 0);

      // R7: chip select held low across back-to-back reads
      r0 = rd_cnt;
      cs_n = 0; rnw_i = 1; kind_i = 2'd0; idle(3);
      ds_b_n = 0; idle(5); ds_b_n = 1; idle(5);
      kind_i = 2'd3;
      ds_b_n = 0; idle(5); ds_b_n = 1; idle(5);
      chk("R7 back-to-back reads", 32'(rd_cnt - r0), 2);
      chk("R7 last kind", 32'(kind_q), 3);

      // R9: address strobe low at the activation edge
      access(0, 2'd2, 1, 1, 1, 2'b00, 16'h0000);
      r0 = rd_cnt; w0 = wr_cnt;
      access(0, 2'd1, 0, 0, 0, 2'b01, 16'h1234);
      chk("R9 kind held", 32'(kind_q), 2);
      chk("R9 old direction read", 32'(rd_cnt - r0), 1);
      chk("R9 no write start", 32'(wr_cnt - w0), 0);

      // R8: ready gating by chip select
      cs_n = 0; busy_i = 1; idle(S + 1);
      chk("R8 busy with select", 32'(rdy_n_o), 1);
      cs_n = 1; idle(S + 1);
      chk("R8 busy without select", 32'(rdy_n_o), 0);
      cs_n = 0; idle(S + 1); busy_i = 0; idle(1);
      chk("R8 not busy", 32'(rdy_n_o), 0);
      cs_n = 1; idle(4);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule